// File: doc/BRIEF.md
# Interrupt Injection Wrapper

This block sits on the instruction path between the fetch memory and a small single-issue 16-bit RISC core. It gives the core interrupt handling without touching the core's datapath. An interrupt is serviced by swapping the fetched instruction for a forced jump-and-link. That jump sends execution to the handler at address 0x0002 and leaves the return address in register 0. The handler later returns by jumping through register 0.

The interrupt request may come from another clock domain. It passes through a flop chain and an edge detector. Each rising edge sets a pending flag. The pending request is serviced only when two things hold at the same time: the fetched word is valid, and the core reports that the boundary in front of that word is safe. The core clears its safe flag on immediate-prefix, add-with-carry, subtract-with-carry and compare instructions, so these interlocked pairs are never split. On each service the block raises a one-cycle taken pulse.

Top module: `irq_splice`

## Requirements
- R1: A synchronous reset clears the pending request. On the first cycle after reset, with a valid word and a safe boundary, `insn_out` equals `fetch_word` and `irq_taken` is 0.
- R2: A rising edge on `irq_req` that is first sampled at clock edge k makes the request pending after edge k+SYNC_STAGES. It can be serviced in the cycle that follows, and not earlier.
- R3: A service drives `insn_out` to 0x0001. This is the jump-and-link opcode 0 in bits 15:12, link register 0 in bits 11:8, base register 0 in bits 7:4 and offset field 1 in bits 3:0, which is scaled by two to reach the handler at 0x0002.
- R4: While `core_safe` is low, a pending request is held, `insn_out` follows `fetch_word` and `irq_taken` stays 0.
- R5: While `fetch_valid` is low, a pending request is held, `insn_out` follows `fetch_word` and `irq_taken` stays 0.
- R6: `irq_taken` is high for exactly the cycles in which a substitution happens. The pending flag clears at the end of that cycle, so the next word passes through unchanged.
- R7: A new request edge that is detected in the same cycle as a service leaves the request pending, and a second service follows on the next safe, valid cycle.
- R8: A request held high for many cycles produces one service only. A new service needs a new rising edge.
- R9: While `rst` is high, no substitution happens and `insn_out` follows `fetch_word`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| irq_req | input | 1 | Interrupt request; may come from another clock domain |
| fetch_word | input | 16 | Instruction word fetched from memory |
| fetch_valid | input | 1 | Qualifies `fetch_word` |
| core_safe | input | 1 | Core reports that the boundary before the current word may be interrupted |
| insn_out | output | 16 | Word passed to the core, substituted on a service |
| irq_taken | output | 1 | One-cycle pulse for each substitution |

## Verification
The request path is due SYNC_STAGES+1 clock edges after the edge that first samples `irq_req`. Substitution and the taken pulse are combinational in the qualifiers, so they are due in the same cycle as `fetch_valid` and `core_safe`. The bench drives every input on the falling edge. It counts rising edges from the sampling edge and samples one time unit after its own drive. Each service window is therefore checked both in the cycle it is due and in the cycles before and after it.

// File: rtl/irqw_pkg.sv
`timescale 1ns/1ps
package irqw_pkg;
    localparam int WORD_W = 16;
    localparam int FLD_W  = 4;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [FLD_W-1:0]  fld_t;

    // register-register-immediate layout used by jump-and-link
    typedef struct packed {
        fld_t op;
        fld_t dst;
        fld_t base;
        fld_t off;
    } rri_word_t;

    localparam fld_t  OP_JUMP_LINK = 4'h0;
    localparam fld_t  LINK_REG     = 4'h0;
    localparam word_t HANDLER_PC   = 16'h0002;

    // offset field counts 16-bit words
    function automatic word_t build_jump_link(input fld_t dst, input fld_t base,
                                              input word_t target);
        rri_word_t w;
        w.op   = OP_JUMP_LINK;
        w.dst  = dst;
        w.base = base;
        w.off  = target[FLD_W:1];
        return w;
    endfunction

    localparam word_t FORCED_WORD = build_jump_link(LINK_REG, LINK_REG, HANDLER_PC);
endpackage

// File: rtl/irq_sync.sv
`timescale 1ns/1ps
module irq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic req_i,
    output logic rise_o
);
    logic [STAGES-1:0] chain_q;
    logic              last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '0;
            last_q  <= 1'b0;
        end else begin
            chain_q[0] <= req_i;
            for (int i = 1; i < STAGES; i++) begin
                chain_q[i] <= chain_q[i-1];
            end
            last_q <= chain_q[STAGES-1];
        end
    end

    assign rise_o = chain_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/irq_pend.sv
`timescale 1ns/1ps
module irq_pend (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic pend_o
);
    typedef enum logic {PEND_IDLE = 1'b0, PEND_HELD = 1'b1} pend_e;
    pend_e state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PEND_IDLE;
        end else if (set_i) begin
            state_q <= PEND_HELD;      // a fresh edge outranks the clear
        end else if (clr_i) begin
            state_q <= PEND_IDLE;
        end
    end

    assign pend_o = (state_q == PEND_HELD);
endmodule

// File: rtl/irq_splice.sv
`timescale 1ns/1ps
module irq_splice
    import irqw_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        irq_req,
    input  logic [15:0] fetch_word,
    input  logic        fetch_valid,
    input  logic        core_safe,
    output logic [15:0] insn_out,
    output logic        irq_taken
);
    logic rise_w;
    logic pend_q;
    logic take_w;

    irq_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk    (clk),
        .rst    (rst),
        .req_i  (irq_req),
        .rise_o (rise_w)
    );

    irq_pend pend_i (
        .clk    (clk),
        .rst    (rst),
        .set_i  (rise_w),
        .clr_i  (take_w),
        .pend_o (pend_q)
    );

    assign take_w    = pend_q & fetch_valid & core_safe & ~rst;
    assign insn_out  = take_w ? FORCED_WORD : fetch_word;
    assign irq_taken = take_w;
endmodule

// File: rtl/irq_splice_chk.sv
`timescale 1ns/1ps
module irq_splice_chk (
    input logic        clk,
    input logic        rst,
    input logic [15:0] fetch_word,
    input logic        fetch_valid,
    input logic        core_safe,
    input logic [15:0] insn_out,
    input logic        irq_taken,
    input logic        rise_w,
    input logic        pend_q
);
    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst) $past(rst) |-> !pend_q); // R1
    AST_EDGE_PENDS: assert property (@(posedge clk) disable iff (rst) rise_w |=> pend_q); // R2
    AST_FORCED_WORD: assert property (@(posedge clk) disable iff (rst) irq_taken |-> insn_out == 16'h0001); // R3
    AST_SAFE_ONLY: assert property (@(posedge clk) disable iff (rst) irq_taken |-> core_safe); // R4
    AST_VALID_ONLY: assert property (@(posedge clk) disable iff (rst) irq_taken |-> fetch_valid); // R5
    AST_HOLD_PENDING: assert property (@(posedge clk) disable iff (rst) (pend_q && !irq_taken) |=> pend_q); // R4
    AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (rst) !irq_taken |-> insn_out == fetch_word); // R5
    AST_TAKEN_NEEDS_PEND: assert property (@(posedge clk) disable iff (rst) irq_taken |-> pend_q); // R6
    AST_CLEAR_AFTER: assert property (@(posedge clk) disable iff (rst) (irq_taken && !rise_w) |=> !pend_q); // R6
    AST_REARM: assert property (@(posedge clk) disable iff (rst) (irq_taken && rise_w) |=> pend_q); // R7
    AST_SINGLE_EDGE: assert property (@(posedge clk) disable iff (rst) rise_w |=> !rise_w); // R8
    AST_NO_TAKE_IN_RST: assert property (@(posedge clk) rst |-> !irq_taken); // R9
endmodule

bind irq_splice irq_splice_chk chk_i (
    .clk         (clk),
    .rst         (rst),
    .fetch_word  (fetch_word),
    .fetch_valid (fetch_valid),
    .core_safe   (core_safe),
    .insn_out    (insn_out),
    .irq_taken   (irq_taken),
    .rise_w      (rise_w),
    .pend_q      (pend_q)
);

// File: tb/irq_splice_tb_top.sv
`timescale 1ns/1ps
module irq_splice_tb_top;
    localparam int N = 2;
    localparam logic [15:0] JL = 16'h0001;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        irq_req = 1'b0;
    logic [15:0] fetch_word = 16'h0000;
    logic        fetch_valid = 1'b0;
    logic        core_safe = 1'b0;
    logic [15:0] insn_out;
    logic        irq_taken;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    irq_splice #(.SYNC_STAGES(N)) dut_i (
        .clk         (clk),
        .rst         (rst),
        .irq_req     (irq_req),
        .fetch_word  (fetch_word),
        .fetch_valid (fetch_valid),
        .core_safe   (core_safe),
        .insn_out    (insn_out),
        .irq_taken   (irq_taken)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // leaves the bench at the falling edge after the sampling rising edge
    task automatic pulse_req();
        @(negedge clk) irq_req = 1'b1;
        @(posedge clk);
        @(negedge clk) irq_req = 1'b0;
    endtask

    task automatic t_reset_state();
        rst = 1'b1; fetch_valid = 1'b1; core_safe = 1'b1; fetch_word = 16'h4321;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk); #1;
        check("R1 taken after reset", {15'd0, irq_taken}, 16'd0);
        check("R1 word after reset", insn_out, 16'h4321);
    endtask

    task automatic t_latency();
        fetch_valid = 1'b1; core_safe = 1'b1; fetch_word = 16'h2312;
        pulse_req();
        for (int k = 1; k <= N + 2; k++) begin
            #1;
            check("R2 taken timing", {15'd0, irq_taken}, (k == N + 1) ? 16'd1 : 16'd0);
            check("R3 word timing", insn_out, (k == N + 1) ? JL : 16'h2312);
            @(negedge clk);
        end
    endtask

    task automatic t_unsafe();
        fetch_valid = 1'b1; core_safe = 1'b0; fetch_word = 16'h8123;
        pulse_req();
        repeat (N + 2) begin
            #1;
            check("R4 held taken", {15'd0, irq_taken}, 16'd0);
            check("R4 held word", insn_out, 16'h8123);
            @(negedge clk);
        end
        core_safe = 1'b1; #1;
        check("R4 serviced when safe", {15'd0, irq_taken}, 16'd1);
        check("R3 forced word", insn_out, JL);
        @(negedge clk); #1;
        check("R6 pulse ends", {15'd0, irq_taken}, 16'd0);
        check("R6 next word passes", insn_out, 16'h8123);
    endtask

    task automatic t_invalid();
        fetch_valid = 1'b0; core_safe = 1'b1; fetch_word = 16'h5A47;
        pulse_req();
        repeat (N + 2) begin
            #1;
            check("R5 held taken", {15'd0, irq_taken}, 16'd0);
            check("R5 held word", insn_out, 16'h5A47);
            @(negedge clk);
        end
        fetch_valid = 1'b1; #1;
        check("R5 serviced when valid", {15'd0, irq_taken}, 16'd1);
        @(negedge clk); #1;
        check("R6 single service", {15'd0, irq_taken}, 16'd0);
    endtask

    task automatic t_overlap();
        fetch_valid = 1'b1; core_safe = 1'b0; fetch_word = 16'h3B08;
        pulse_req();
        repeat (N + 2) @(negedge clk);
        pulse_req();
        repeat (N - 1) @(negedge clk);
        core_safe = 1'b1; #1;
        check("R7 first service", {15'd0, irq_taken}, 16'd1);
        @(negedge clk); #1;
        check("R7 second service", {15'd0, irq_taken}, 16'd1);
        check("R7 second word", insn_out, JL);
        @(negedge clk); #1;
        check("R7 then idle", {15'd0, irq_taken}, 16'd0);
    endtask

    task automatic t_level();
        int seen = 0;
        fetch_valid = 1'b1; core_safe = 1'b1; fetch_word = 16'h6102;
        @(negedge clk) irq_req = 1'b1;
        repeat (20) begin
            @(negedge clk); #1;
            if (irq_taken) seen++;
        end
        irq_req = 1'b0;
        repeat (5) begin
            @(negedge clk); #1;
            if (irq_taken) seen++;
        end
        check("R8 services for held level", 16'(seen), 16'd1);
    endtask

    task automatic t_reset_gate();
        fetch_valid = 1'b0; core_safe = 1'b1; fetch_word = 16'h7E11;
        pulse_req();
        repeat (N + 1) @(negedge clk);
        rst = 1'b1; fetch_valid = 1'b1; #1;
        check("R9 no take in reset", {15'd0, irq_taken}, 16'd0);
        check("R9 word in reset", insn_out, 16'h7E11);
        @(negedge clk) rst = 1'b0; #1;
        check("R1 pending cleared", {15'd0, irq_taken}, 16'd0);
    endtask

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset_state();
        t_latency();
        t_unsafe();
        t_invalid();
        t_overlap();
        t_level();
        t_reset_gate();
        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule